// File: doc/BRIEF.md
# Receive input crossbar multiplexer

This block sits between four real-valued ADC sample streams and the inputs of four downconverter channels. Each channel has an I input and a Q input. A 32-bit configuration word picks, for every one of these eight inputs, which ADC feeds it. The Q inputs can also be tied to constant zero as a group, which is how the receive chain is set up for real-only reception.

Samples arrive on four signed buses that share one valid strobe. The routed samples leave on eight registered buses, four I and four Q, together with a registered valid strobe. A configuration write port loads a new routing word. The block checks every write. It ignores an illegal write, keeps the routing already in force, and raises a sticky error flag. The next legal write clears the flag.

Top module: `rxmux_xbar`

## Requirements
- R1: The configuration word holds eight 4-bit fields. Nibble 2k (bits 8k+3..8k) selects the source of channel k's I input, and nibble 2k+1 (bits 8k+7..8k+4) selects the source of its Q input, for k = 0..3. An I code n in 0..3 routes ADC n (adc_data bits 16n+15..16n at the default width) to i_data bits 16k+15..16k.
- R2: A Q code n in 0..3 routes ADC n to q_data bits 16k+15..16k.
- R3: When every Q field holds 0xF, all four Q outputs carry zero while the I outputs follow their own fields.
- R4: A write that has any I field with a value from 4 to 15 is illegal.
- R5: A write that has any Q field with a value from 4 to 14 is illegal. A write is also illegal when some Q fields hold 0xF and others do not.
- R6: An illegal write leaves the routing unchanged and sets cfg_err one cycle later. cfg_err stays set through cycles with no write and through further illegal writes. It clears one cycle after the next legal write.
- R7: out_valid equals in_valid delayed by one clock. i_data and q_data are loaded only on a valid sample and otherwise hold their last values.
- R8: A sample presented in the same cycle as an accepted write is routed with the old configuration. Samples from the next cycle on use the new one, and every sample is routed by one configuration as a whole.
- R9: Reset is synchronous and active high. It clears out_valid, i_data, q_data and cfg_err, and loads the word 0xF0F0F0F0: every I input takes ADC 0 and every Q input is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| in_valid | input | 1 | Input sample strobe common to all ADCs |
| adc_data | input | 4*SAMPLE_W | Four signed ADC samples, ADC n at slice n |
| out_valid | output | 1 | Output sample strobe |
| i_data | output | 4*SAMPLE_W | Registered I inputs, channel k at slice k |
| q_data | output | 4*SAMPLE_W | Registered Q inputs, channel k at slice k |
| cfg_err | output | 1 | Sticky flag for a rejected write |

## Verification
The bench goes after the cases a design could most easily get wrong:

- **Write and sample in the same cycle.** A design that applied the new word at once would route that sample with the new configuration.
- **Mixed zero and non-zero Q fields.** A design that checked each field alone would accept this mix and zero only some Q outputs.
- **Q codes 4 to 14.** A design that treated these as zero or as an ADC index would accept an illegal word.
- **Error flag persistence.** The bench keeps cfg_err under observation through idle cycles and through repeated bad writes. A design that was not sticky, or that cleared the flag on any write, would drop the flag early.
- **Rejected writes.** After each rejected write, the bench streams samples to show that the earlier routing is still in force.

Random legal and illegal words, mixed with random valid patterns, are compared against a model of the routing held in the bench.

// File: rtl/rxmux_pkg.sv
package rxmux_pkg;
  localparam int NUM_CH   = 4;
  localparam int NUM_ADC  = 4;
  localparam int FIELD_W  = 4;
  localparam int CFG_W    = 2 * NUM_CH * FIELD_W;
  localparam logic [FIELD_W-1:0] ZERO_CODE = '1;
  localparam logic [FIELD_W-1:0] ADC_LIM   = FIELD_W'(NUM_ADC);

  // One channel's selection pair; i sits in the low nibble.
  typedef struct packed {
    logic [FIELD_W-1:0] q;
    logic [FIELD_W-1:0] i;
  } lane_sel_t;

  typedef lane_sel_t [NUM_CH-1:0] route_cfg_t;

  // Default routing: all I from ADC 0, all Q forced to zero.
  function automatic route_cfg_t reset_route();
    route_cfg_t r;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      r[ch].i = '0;
      r[ch].q = ZERO_CODE;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxmux_cfg.sv
module rxmux_cfg
  import rxmux_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output route_cfg_t       route,
  output logic             zero_mode,
  output logic             err
);
  route_cfg_t wr_fields;
  logic       wr_legal;
  logic       wr_zero;

  assign wr_fields = route_cfg_t'(wdata);

  always_comb begin
    int nzero;
    nzero    = 0;
    wr_legal = 1'b1;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (wr_fields[ch].i >= ADC_LIM) wr_legal = 1'b0;
      if (wr_fields[ch].q == ZERO_CODE) nzero++;
      else if (wr_fields[ch].q >= ADC_LIM) wr_legal = 1'b0;
    end
    if (nzero != 0 && nzero != NUM_CH) wr_legal = 1'b0;
    wr_zero = (nzero == NUM_CH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route     <= reset_route();
      zero_mode <= 1'b1;
      err       <= 1'b0;
    end else if (we) begin
      if (wr_legal) begin
        route     <= wr_fields;
        zero_mode <= wr_zero;
      end
      err <= ~wr_legal;
    end
  end

  // R6: rejected write keeps the routing
  a_r6_keep_route: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_legal) |=> $stable(route) && $stable(zero_mode));
  // R6: rejected write raises the flag
  a_r6_err_set: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_legal) |=> err);
  // R6: flag only moves on a write
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(err));
  // R5: an accepted word never mixes zero and non-zero Q codes
  a_r5_zero_consistent: assert property (@(posedge clk) disable iff (rst)
    zero_mode |-> (route[0].q == ZERO_CODE && route[NUM_CH-1].q == ZERO_CODE));
endmodule

// File: rtl/rxmux_sel.sv
module rxmux_sel
  import rxmux_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [FIELD_W-1:0]                code,
  input  logic [NUM_ADC-1:0][SAMPLE_W-1:0]  adc,
  output logic [SAMPLE_W-1:0]               y
);
  // Codes outside the ADC range (the zero code) select nothing.
  always_comb begin
    y = '0;
    for (int a = 0; a < NUM_ADC; a++)
      if (code == FIELD_W'(a)) y = adc[a];
  end
endmodule

// File: rtl/rxmux_xbar.sv
module rxmux_xbar
  import rxmux_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [CFG_W-1:0]             cfg_wdata,
  input  logic                         in_valid,
  input  logic [NUM_ADC*SAMPLE_W-1:0]  adc_data,
  output logic                         out_valid,
  output logic [NUM_CH*SAMPLE_W-1:0]   i_data,
  output logic [NUM_CH*SAMPLE_W-1:0]   q_data,
  output logic                         cfg_err
);
  localparam int BUS_W = NUM_CH * SAMPLE_W;

  route_cfg_t                        route;
  logic                              zero_mode;
  logic [NUM_ADC-1:0][SAMPLE_W-1:0]  adc_arr;
  logic [BUS_W-1:0]                  i_sel;
  logic [BUS_W-1:0]                  q_sel;

  assign adc_arr = adc_data;

  rxmux_cfg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .route     (route),
    .zero_mode (zero_mode),
    .err       (cfg_err)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    rxmux_sel #(.SAMPLE_W(SAMPLE_W)) u_isel (
      .code (route[ch].i),
      .adc  (adc_arr),
      .y    (i_sel[ch*SAMPLE_W +: SAMPLE_W])
    );
    rxmux_sel #(.SAMPLE_W(SAMPLE_W)) u_qsel (
      .code (route[ch].q),
      .adc  (adc_arr),
      .y    (q_sel[ch*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      i_data    <= '0;
      q_data    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        i_data <= i_sel;
        q_data <= q_sel;
      end
    end
  end

  // R7: one cycle from input strobe to output strobe
  a_r7_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r7_valid_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R7: outputs hold between samples
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(i_data) && $stable(q_data)));
  // R3: zero mode forces every Q output to zero
  a_r3_zero_q: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(zero_mode)) |-> (q_data == '0));
endmodule

// File: tb/sim_rxmux_xbar.sv
module sim_rxmux_xbar;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst;
  logic           cfg_we;
  logic [31:0]    cfg_wdata;
  logic           in_valid;
  logic [4*W-1:0] adc_data;
  logic           out_valid;
  logic [4*W-1:0] i_data;
  logic [4*W-1:0] q_data;
  logic           cfg_err;

  rxmux_xbar #(.SAMPLE_W(W)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .adc_data(adc_data), .out_valid(out_valid),
    .i_data(i_data), .q_data(q_data), .cfg_err(cfg_err)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0]        m_cfg;
  logic               m_err;
  logic [3:0][W-1:0]  e_i, e_q;

  function automatic bit is_legal(logic [31:0] w);
    int nz = 0;
    for (int ch = 0; ch < 4; ch++) begin
      logic [3:0] fi = w[8*ch +: 4];
      logic [3:0] fq = w[8*ch+4 +: 4];
      if (fi > 3) return 0;
      if (fq == 4'hF) nz++;
      else if (fq > 3) return 0;
    end
    return (nz == 0 || nz == 4);
  endfunction

  function automatic logic [31:0] mk(logic [3:0] i0, q0, i1, q1, i2, q2, i3, q3);
    return {q3, i3, q2, i2, q1, i1, q0, i0};
  endfunction

  function automatic logic [W-1:0] pick(logic [3:0] code, logic [3:0][W-1:0] a);
    return (code <= 3) ? a[code[1:0]] : '0;
  endfunction

  function automatic logic [31:0] rand_legal(bit zero);
    logic [31:0] w;
    for (int ch = 0; ch < 4; ch++) begin
      w[8*ch +: 4]   = 4'($urandom % 4);
      w[8*ch+4 +: 4] = zero ? 4'hF : 4'($urandom % 4);
    end
    return w;
  endfunction

  function automatic logic [31:0] rand_illegal();
    logic [31:0] w;
    int f;
    int kind;
    w    = rand_legal(1'($urandom % 2));
    f    = $urandom % 4;
    kind = $urandom % 3;
    if (kind == 0) w[8*f +: 4] = 4'(4 + $urandom % 12);
    else if (kind == 1) w[8*f+4 +: 4] = 4'(4 + $urandom % 11);
    else w[8*f+4 +: 4] = (w[8*f+4 +: 4] == 4'hF) ? 4'($urandom % 4) : 4'hF;
    return w;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle (called just after a falling edge), then check after the rise.
  task automatic step(bit we, logic [31:0] wd, bit vld, logic [3:0][W-1:0] adc, string tag);
    cfg_we = we; cfg_wdata = wd; in_valid = vld; adc_data = adc;
    if (vld) begin
      for (int ch = 0; ch < 4; ch++) begin
        e_i[ch] = pick(m_cfg[8*ch +: 4], adc);
        e_q[ch] = pick(m_cfg[8*ch+4 +: 4], adc);
      end
    end
    @(posedge clk); #1;
    if (we) begin
      if (is_legal(wd)) begin m_cfg = wd; m_err = 1'b0; end
      else m_err = 1'b1;
    end
    chk({tag, " valid"}, 64'(out_valid), 64'(vld));
    chk({tag, " i"}, i_data, e_i);
    chk({tag, " q"}, q_data, e_q);
    chk({tag, " err"}, 64'(cfg_err), 64'(m_err));
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
  endtask

  function automatic logic [3:0][W-1:0] rsamp();
    logic [3:0][W-1:0] a;
    for (int n = 0; n < 4; n++) a[n] = W'($urandom);
    return a;
  endfunction

  logic [3:0][W-1:0] dsamp;

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; in_valid = 1'b0; adc_data = '0;
    m_cfg = 32'hF0F0F0F0; m_err = 1'b0; e_i = '0; e_q = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9 valid", 64'(out_valid), 64'd0);
    chk("R9 i", i_data, 64'd0);
    chk("R9 q", q_data, 64'd0);
    chk("R9 err", 64'(cfg_err), 64'd0);
    rst = 1'b0;
    dsamp = {16'h4444, 16'h3333, 16'h2222, 16'h1111};
    step(0, 0, 1, dsamp, "R9 default route");

    // R1 and R2: every field distinct
    step(1, mk(3,2, 1,0, 2,3, 0,1), 0, dsamp, "R1 write");
    step(0, 0, 1, dsamp, "R1 R2 route");
    step(0, 0, 1, {16'h8001, 16'h7FFF, 16'hFFFF, 16'h0000}, "R2 route signed");
    // R3: zero mode with varied I
    step(1, mk(2,15, 3,15, 0,15, 1,15), 0, dsamp, "R3 write");
    step(0, 0, 1, dsamp, "R3 zero q");
    // R4: illegal I code, routing kept
    step(1, mk(5,15, 3,15, 0,15, 1,15), 0, dsamp, "R4 illegal i");
    step(0, 0, 1, {16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD}, "R6 kept after R4");
    // R6: sticky through idle cycles
    step(0, 0, 0, dsamp, "R6 sticky idle");
    step(0, 0, 0, dsamp, "R7 hold");
    step(1, mk(0,0, 1,1, 2,2, 3,3), 0, dsamp, "R6 clear");
    step(0, 0, 1, dsamp, "R2 identity");
    // R5: bad Q code, then mixed zero
    step(1, mk(0,7, 1,1, 2,2, 3,3), 0, dsamp, "R5 q code 7");
    step(1, mk(0,15, 1,1, 2,15, 3,3), 0, dsamp, "R5 mixed zero");
    step(0, 0, 1, {16'h0D0D, 16'h0C0C, 16'h0B0B, 16'h0A0A}, "R6 kept after R5");
    step(1, mk(0,14, 1,1, 2,2, 3,3), 0, dsamp, "R5 q code 14");
    // R8: write and sample in one cycle use the old routing, then the new
    step(1, mk(3,3, 3,3, 3,3, 3,3), 1, dsamp, "R8 same cycle");
    step(0, 0, 1, dsamp, "R8 next cycle");
    step(1, mk(1,15, 1,15, 1,15, 1,15), 1, {16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0}, "R8 to zero");
    step(0, 0, 1, {16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0}, "R8 R3 after");
    // Back-to-back samples
    for (int k = 0; k < 4; k++) step(0, 0, 1, rsamp(), "R7 back to back");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int r = $urandom % 10;
      bit vld = 1'($urandom % 3 != 0);
      if (r < 3)      step(1, rand_legal(1'($urandom % 2)), vld, rsamp(), "R1 random legal");
      else if (r < 5) step(1, rand_illegal(), vld, rsamp(), "R5 random illegal");
      else            step(0, 0, vld, rsamp(), "R7 random stream");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule